// File: doc/BRIEF.md
# Link Training Stall Recovery Supervisor

The block watches a serial link while the link controller trains. After a start request it looks at a link-up flag in the upper controller debug word. If the link is not up, it waits one poll interval, reads the lane receiver status register over a simple PHY register request/done port, and samples the 6-bit training-state field in the lower debug word. A training state of receiver-lock recovery, combined with a receiver-valid bit of zero, marks a stalled speed change.

For a stall, the block resets the PHY receive path. It reads the lane receiver override register, writes it back with two override bits set, holds for another poll interval, then reads it again and writes it back with those two bits cleared. Every other bit of the register is preserved. Polling continues until the link comes up or a set number of polls has passed without link-up. The outcome is reported on two held flags, and a new start request clears both.

Top module: `train_stall_recover`

## Requirements
- R1: While reset is asserted and after it is released, `link_up_o`, `fail_o` and `phy_req_o` are 0 until a start request is accepted.
- R2: A start request in the idle state clears `link_up_o` and `fail_o` on the following clock edge and begins supervision. A start request while supervision is running is ignored, so the poll count and the PHY traffic continue unchanged.
- R3: Link-up is bit 4 (`LINK_BIT`) of `dbg_hi_i`, and no other bit of that word counts as link-up. When the bit is seen, `link_up_o` rises one cycle after the check state is entered, holds until the next accepted start, and no further PHY request is made.
- R4: Each poll that finds no link-up waits `POLL_CYCLES` cycles and then issues one PHY read of the receiver status address 0x100D. The read request appears `POLL_CYCLES`+1 cycles after the start edge.
- R5: A stall is `dbg_lo_i[5:0]` equal to 0x0D while bit 0 of the status read data is 0. Any other training state, or receiver-valid equal to 1, causes no override access.
- R6: On a stall, the override register at address 0x1005 is read and written back with bits 3 and 5 set and all other bits kept. After `POLL_CYCLES` cycles it is read and written back with bits 3 and 5 cleared. The second read request appears `POLL_CYCLES`+2 cycles after the first write completes.
- R7: After `MAX_POLLS` polls without link-up, `fail_o` rises and holds until the next accepted start. Exactly `MAX_POLLS` status reads have been made by then.
- R8: `phy_req_o` stays high with stable `phy_wr_o`, `phy_addr_o` and `phy_wdata_o` until `phy_done_i` is seen. Only one request is outstanding at a time.
- R9: `link_up_o` and `fail_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, one-cycle pulse |
| dbg_lo_i | input | 32 | Lower controller debug word (training state in [5:0]) |
| dbg_hi_i | input | 32 | Upper controller debug word (link-up flag at LINK_BIT) |
| phy_req_o | output | 1 | PHY register access request |
| phy_wr_o | output | 1 | 1 = write, 0 = read |
| phy_addr_o | output | 16 | PHY register address |
| phy_wdata_o | output | 16 | PHY write data |
| phy_done_i | input | 1 | Access complete, one-cycle pulse |
| phy_rdata_i | input | 16 | PHY read data, valid with phy_done_i |
| link_up_o | output | 1 | Link came up (held) |
| fail_o | output | 1 | Poll budget exhausted without link (held) |

## Verification
The bound checker covers the properties that hold on every cycle: the handshake stability of the PHY port, the mutual exclusion and holding of the two result flags, silence on the PHY port once the link is up, and the restriction of PHY traffic to the two legal addresses with writes only to the override register. Only the bench scenarios can show the ordering and timing of a whole poll. These cover the interval before the status read, stall recognition against the masked training state and the receiver-valid bit, preservation of the untouched override bits across both read-modify-write passes, the exact hold length, the poll budget, and the ignoring of a start request during supervision.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WAIT,
    ST_STATUS,
    ST_SET_RD,
    ST_SET_WR,
    ST_HOLD,
    ST_CLR_RD,
    ST_CLR_WR
  } tsr_state_e;

endpackage

// File: rtl/tsr_interval.sv
// Down-counter that measures one programmable interval after a load pulse.
module tsr_interval #(
  parameter int unsigned CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expire_o
);
  localparam int unsigned TW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [TW-1:0] LOAD_VAL = TW'(CYCLES - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;

  assign expire_o = run_q && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (load_i) begin
      cnt_d = LOAD_VAL;
      run_d = 1'b1;
    end else if (expire_o) begin
      run_d = 1'b0;
    end else if (run_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end
endmodule

// File: rtl/tsr_phy_port.sv
// Holds one PHY register access on a request/done handshake.
module tsr_phy_port #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              phy_req_o,
  output logic              phy_wr_o,
  output logic [ADDR_W-1:0] phy_addr_o,
  output logic [DATA_W-1:0] phy_wdata_o,
  input  logic              phy_done_i,
  input  logic [DATA_W-1:0] phy_rdata_i,
  output logic              rsp_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  logic              req_q, req_d;
  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              rsp_q, rsp_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic              take;
  logic              finish;

  assign take   = go_i && !req_q;
  assign finish = req_q && phy_done_i;

  always_comb begin
    req_d   = req_q;
    wr_d    = wr_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    rsp_d   = 1'b0;
    rdat_d  = rdat_q;
    if (take) begin
      req_d   = 1'b1;
      wr_d    = wr_i;
      addr_d  = addr_i;
      wdata_d = wdata_i;
    end else if (finish) begin
      req_d  = 1'b0;
      rsp_d  = 1'b1;
      rdat_d = phy_rdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rsp_q   <= 1'b0;
      rdat_q  <= '0;
    end else begin
      req_q <= req_d;
      rsp_q <= rsp_d;
      if (take) begin
        wr_q    <= wr_d;
        addr_q  <= addr_d;
        wdata_q <= wdata_d;
      end
      if (finish) begin
        rdat_q <= rdat_d;
      end
    end
  end

  assign phy_req_o   = req_q;
  assign phy_wr_o    = wr_q;
  assign phy_addr_o  = addr_q;
  assign phy_wdata_o = wdata_q;
  assign rsp_o       = rsp_q;
  assign rsp_data_o  = rdat_q;
endmodule

// File: rtl/train_stall_recover.sv
module train_stall_recover
  import tsr_pkg::*;
#(
  parameter int unsigned          DBG_W       = 32,
  parameter int unsigned          ADDR_W      = 16,
  parameter int unsigned          DATA_W      = 16,
  parameter int unsigned          LTSSM_W     = 6,
  parameter int unsigned          LINK_BIT    = 4,
  parameter int unsigned          POLL_CYCLES = 250000,
  parameter int unsigned          MAX_POLLS   = 200,
  parameter logic [LTSSM_W-1:0]   STALL_STATE = 6'h0D,
  parameter logic [ADDR_W-1:0]    STS_ADDR    = 16'h100D,
  parameter logic [ADDR_W-1:0]    OVR_ADDR    = 16'h1005,
  parameter logic [DATA_W-1:0]    OVR_MASK    = 16'h0028
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DBG_W-1:0]  dbg_lo_i,
  input  logic [DBG_W-1:0]  dbg_hi_i,
  output logic              phy_req_o,
  output logic              phy_wr_o,
  output logic [ADDR_W-1:0] phy_addr_o,
  output logic [DATA_W-1:0] phy_wdata_o,
  input  logic              phy_done_i,
  input  logic [DATA_W-1:0] phy_rdata_i,
  output logic              link_up_o,
  output logic              fail_o
);
  localparam int unsigned PW = $clog2(MAX_POLLS + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS);

  tsr_state_e        state_q, state_d;
  logic [PW-1:0]     polls_q, polls_d;
  logic              up_q, up_d;
  logic              fail_q, fail_d;
  logic              tmr_load;
  logic              tmr_expire;
  logic              go;
  logic              go_wr;
  logic [ADDR_W-1:0] go_addr;
  logic [DATA_W-1:0] go_wdata;
  logic              rsp;
  logic [DATA_W-1:0] rsp_data;
  logic              link_seen;
  logic              stalled;
  logic              unused_dbg;

  assign link_seen  = dbg_hi_i[LINK_BIT];
  assign stalled    = (dbg_lo_i[LTSSM_W-1:0] == STALL_STATE) && !rsp_data[0];
  assign unused_dbg = ^{dbg_hi_i, dbg_lo_i[DBG_W-1:LTSSM_W]};

  tsr_interval #(.CYCLES(POLL_CYCLES)) i_interval (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (tmr_load),
    .expire_o (tmr_expire)
  );

  tsr_phy_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_phy_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (go),
    .wr_i        (go_wr),
    .addr_i      (go_addr),
    .wdata_i     (go_wdata),
    .phy_req_o   (phy_req_o),
    .phy_wr_o    (phy_wr_o),
    .phy_addr_o  (phy_addr_o),
    .phy_wdata_o (phy_wdata_o),
    .phy_done_i  (phy_done_i),
    .phy_rdata_i (phy_rdata_i),
    .rsp_o       (rsp),
    .rsp_data_o  (rsp_data)
  );

  always_comb begin
    state_d  = state_q;
    polls_d  = polls_q;
    up_d     = up_q;
    fail_d   = fail_q;
    tmr_load = 1'b0;
    go       = 1'b0;
    go_wr    = 1'b0;
    go_addr  = STS_ADDR;
    go_wdata = '0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          up_d    = 1'b0;
          fail_d  = 1'b0;
          polls_d = '0;
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (link_seen) begin
          up_d    = 1'b1;
          state_d = ST_IDLE;
        end else if (polls_q == POLL_LAST) begin
          fail_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          tmr_load = 1'b1;
          state_d  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (tmr_expire) begin
          go      = 1'b1;
          go_addr = STS_ADDR;
          state_d = ST_STATUS;
        end
      end
      ST_STATUS: begin
        if (rsp) begin
          if (stalled) begin
            go      = 1'b1;
            go_addr = OVR_ADDR;
            state_d = ST_SET_RD;
          end else begin
            polls_d = polls_q + 1'b1;
            state_d = ST_CHECK;
          end
        end
      end
      ST_SET_RD: begin
        if (rsp) begin
          go       = 1'b1;
          go_wr    = 1'b1;
          go_addr  = OVR_ADDR;
          go_wdata = rsp_data | OVR_MASK;
          state_d  = ST_SET_WR;
        end
      end
      ST_SET_WR: begin
        if (rsp) begin
          tmr_load = 1'b1;
          state_d  = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (tmr_expire) begin
          go      = 1'b1;
          go_addr = OVR_ADDR;
          state_d = ST_CLR_RD;
        end
      end
      ST_CLR_RD: begin
        if (rsp) begin
          go       = 1'b1;
          go_wr    = 1'b1;
          go_addr  = OVR_ADDR;
          go_wdata = rsp_data & ~OVR_MASK;
          state_d  = ST_CLR_WR;
        end
      end
      ST_CLR_WR: begin
        if (rsp) begin
          polls_d = polls_q + 1'b1;
          state_d = ST_CHECK;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      polls_q <= '0;
      up_q    <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      polls_q <= polls_d;
      up_q    <= up_d;
      fail_q  <= fail_d;
    end
  end

  assign link_up_o = up_q;
  assign fail_o    = fail_q;
endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
  parameter int unsigned       ADDR_W   = 16,
  parameter int unsigned       DATA_W   = 16,
  parameter logic [ADDR_W-1:0] STS_ADDR = 16'h100D,
  parameter logic [ADDR_W-1:0] OVR_ADDR = 16'h1005
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              phy_req_o,
  input logic              phy_wr_o,
  input logic [ADDR_W-1:0] phy_addr_o,
  input logic [DATA_W-1:0] phy_wdata_o,
  input logic              phy_done_i,
  input logic              link_up_o,
  input logic              fail_o
);
  assert_req_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req_o && !phy_done_i |=> phy_req_o && $stable(phy_wr_o) && $stable(phy_addr_o) && $stable(phy_wdata_o));

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_up_o && fail_o));

  assert_link_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    link_up_o && !start_i |=> link_up_o);

  assert_fail_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o && !start_i |=> fail_o);

  assert_quiet_after_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    link_up_o |-> !phy_req_o);

  assert_legal_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req_o |-> (phy_addr_o == STS_ADDR) || (phy_addr_o == OVR_ADDR));

  assert_write_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req_o && phy_wr_o |-> phy_addr_o == OVR_ADDR);
endmodule

bind train_stall_recover tsr_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STS_ADDR(STS_ADDR), .OVR_ADDR(OVR_ADDR)
) i_tsr_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .phy_req_o   (phy_req_o),
  .phy_wr_o    (phy_wr_o),
  .phy_addr_o  (phy_addr_o),
  .phy_wdata_o (phy_wdata_o),
  .phy_done_i  (phy_done_i),
  .link_up_o   (link_up_o),
  .fail_o      (fail_o)
);

// File: tb/test_train_stall_recover.sv
`timescale 1ns/1ps
module test_train_stall_recover;
  localparam int unsigned IV   = 20;
  localparam int unsigned NPOL = 5;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] dbg_lo_i;
  logic [31:0] dbg_hi_i;
  logic        phy_req_o;
  logic        phy_wr_o;
  logic [15:0] phy_addr_o;
  logic [15:0] phy_wdata_o;
  logic        phy_done_i;
  logic [15:0] phy_rdata_i;
  logic        link_up_o;
  logic        fail_o;

  int n_chk;
  int n_bad;
  int cyc;
  bit ended;

  // PHY model state
  logic [15:0] ovr_reg;
  logic [15:0] sts_reg;
  int lat;
  int n_sts_rd;
  int n_ovr_wr;
  int n_clr_wr;
  int set_cyc;
  int hold_diff;
  bit hold_armed;
  int first_sts_cyc;
  bit sts_armed;
  logic [15:0] set_val;

  train_stall_recover #(.POLL_CYCLES(IV), .MAX_POLLS(NPOL)) i_train_stall_recover (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .dbg_lo_i(dbg_lo_i), .dbg_hi_i(dbg_hi_i),
    .phy_req_o(phy_req_o), .phy_wr_o(phy_wr_o), .phy_addr_o(phy_addr_o),
    .phy_wdata_o(phy_wdata_o), .phy_done_i(phy_done_i), .phy_rdata_i(phy_rdata_i),
    .link_up_o(link_up_o), .fail_o(fail_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // PHY register model, responds two cycles after a request is seen
  initial begin
    phy_done_i  = 1'b0;
    phy_rdata_i = '0;
    lat = 0;
    forever begin
      @(negedge clk);
      if (phy_done_i) begin
        phy_done_i = 1'b0;
        lat = 0;
      end else if (phy_req_o) begin
        if (lat == 0 && !phy_wr_o && phy_addr_o == 16'h1005 && hold_armed) begin
          hold_diff  = cyc - set_cyc;
          hold_armed = 1'b0;
        end
        if (lat == 0 && !phy_wr_o && phy_addr_o == 16'h100D && sts_armed) begin
          first_sts_cyc = cyc;
          sts_armed     = 1'b0;
        end
        lat++;
        if (lat >= 2) begin
          phy_done_i = 1'b1;
          lat = 0;
          if (phy_wr_o) begin
            n_ovr_wr++;
            ovr_reg = phy_wdata_o;
            if ((phy_wdata_o & 16'h0028) == 16'h0028) begin
              set_val    = phy_wdata_o;
              set_cyc    = cyc;
              hold_armed = 1'b1;
            end else begin
              n_clr_wr++;
            end
          end else if (phy_addr_o == 16'h100D) begin
            n_sts_rd++;
            phy_rdata_i = sts_reg;
          end else begin
            phy_rdata_i = ovr_reg;
          end
        end
      end
    end
  end

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(negedge clk);
      wd++;
      if (wd > 100000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected below 100000", wd);
        finish_run();
      end
    end
  end

  task automatic clear_model();
    n_sts_rd = 0; n_ovr_wr = 0; n_clr_wr = 0;
    hold_armed = 1'b0; hold_diff = -1;
    sts_armed = 1'b1; first_sts_cyc = -1;
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && !link_up_o && !fail_o; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; dbg_lo_i = '0; dbg_hi_i = '0;
    ovr_reg = 16'h0; sts_reg = 16'h0;
    clear_model();
    repeat (3) @(negedge clk);
    chk("R1 link_up in reset", link_up_o, 0);
    chk("R1 fail in reset", fail_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle outputs after reset", {29'd0, link_up_o, fail_o, phy_req_o}, 0);
  endtask

  // no link, no stall: interval timing, poll budget, then fail
  task automatic t_timeout();
    int t0;
    clear_model();
    dbg_hi_i = 32'hFFFF_FFEF;
    dbg_lo_i = 32'h0000_000C;
    sts_reg  = 16'h0000;
    pulse_start();
    t0 = cyc;
    wait_done();
    chk("R4 first status read delay", first_sts_cyc - t0, IV + 1);
    chk("R7 fail raised", fail_o, 1);
    chk("R3 other debug bits not link-up", link_up_o, 0);
    chk("R7 status reads at fail", n_sts_rd, NPOL);
    chk("R5 no override access for other state", n_ovr_wr, 0);
    repeat (10) @(negedge clk);
    chk("R7 fail held", fail_o, 1);
  endtask

  // start clears fail; link already up gives link_up one cycle later
  task automatic t_link_now();
    clear_model();
    dbg_hi_i = 32'h0000_0010;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk("R2 fail cleared by start", fail_o, 0);
    chk("R2 link_up low right after start", link_up_o, 0);
    @(negedge clk);
    chk("R3 link_up one cycle after check", link_up_o, 1);
    chk("R9 fail low with link up", fail_o, 0);
    repeat (IV + 10) @(negedge clk);
    chk("R3 no PHY access when link up", n_sts_rd, 0);
    chk("R3 link_up held", link_up_o, 1);
  endtask

  // training state matches but receiver valid is set: no recovery
  task automatic t_valid_high();
    clear_model();
    dbg_hi_i = 32'h0;
    dbg_lo_i = 32'h0000_000D;
    sts_reg  = 16'h0001;
    pulse_start();
    chk("R2 link_up cleared by start", link_up_o, 0);
    wait_done();
    chk("R5 valid high means no override access", n_ovr_wr, 0);
    chk("R7 fail after budget with valid high", fail_o, 1);
  endtask

  // stall with masked state bits: recovery pulse then link comes up
  task automatic t_stall();
    clear_model();
    dbg_hi_i = 32'h0;
    dbg_lo_i = 32'hFFFF_FFCD;
    sts_reg  = 16'hFFFE;
    ovr_reg  = 16'hA041;
    pulse_start();
    for (int i = 0; i < 5000 && n_clr_wr == 0; i++) @(negedge clk);
    dbg_hi_i = 32'h0000_0010;
    wait_done();
    chk("R5 stall detected", n_ovr_wr, 2);
    chk("R6 set write keeps other bits", set_val, 16'hA069);
    chk("R6 clear write restores register", ovr_reg, 16'hA041);
    chk("R6 hold length", hold_diff, IV + 2);
    chk("R3 link_up after recovery", link_up_o, 1);
    chk("R9 no fail with link up", fail_o, 0);
  endtask

  // start during supervision is ignored
  task automatic t_start_ignored();
    clear_model();
    dbg_hi_i = 32'h0;
    dbg_lo_i = 32'h0000_0000;
    sts_reg  = 16'h0000;
    pulse_start();
    for (int i = 0; i < 5000 && n_sts_rd < 2; i++) @(negedge clk);
    pulse_start();
    wait_done();
    chk("R2 start while running ignored", n_sts_rd, NPOL);
    chk("R2 fail still raised", fail_o, 1);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0; ended = 1'b0;
    t_reset();
    t_timeout();
    t_link_now();
    t_valid_high();
    t_stall();
    t_start_ignored();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule